// File: doc/BRIEF.md
# Rotating-Priority Interrupt Controller

This block gathers eight interrupt request lines and decides which of them, if any, may interrupt the processor. Each line can be captured on a rising edge or followed as a level. The choice is made per line through a trigger-mode register, which is limited by a fixed per-instance capability mask. Pending requests that are not masked compete in a circular priority order. A rotation offset picks the line that has top rank. A request is signalled only when it outranks everything currently in service.

Software reaches the block through a byte-wide port with a single address bit. An initialization sequence of two to four words resets the controller. It also stores a vector base and selects automatic end-of-interrupt and special fully nested behaviour. Operational command words do the following:
- end interrupts, either non-specifically or for a named line, with or without rotating priority;
- set the priority offset directly;
- arm a poll read;
- select what address 0 reads back;
- turn special mask mode on or off.

The processor acknowledges through a dedicated input. A poll read also counts as an acknowledge.

Top module: `rotprio_intc`

## Requirements
- R1: After reset the interrupt request output is 0, the request, in-service and mask registers read 0, the vector base is 0 and the acknowledge level output shows 7.
- R2: A line in edge mode (trigger bit 0) sets its request bit on a 0-to-1 change of its input. The bit stays set after the input falls. A line held high after its request bit is cleared does not set the bit again.
- R3: A line in level mode (trigger bit 1) has a request bit that follows its input. A trigger-register write stores the written byte ANDed with the instance capability mask TRIG_MASK; with the default 8'hF8, lines 0 to 2 stay in edge mode.
- R4: The candidates are the request bits AND NOT the mask. The candidate ranked first wins. Rank r belongs to line (r + offset) mod 8, and rank 0 is the highest. The interrupt request output is registered one clock after the winner appears.
- R5: A winner raises the request only if its rank is strictly better than that of the best in-service bit. In special mask mode, masked in-service bits are left out of this comparison. On a master instance with special fully nested mode, in-service bit CASC_LINE (default 2) is also left out.
- R6: The acknowledge-level output gives the winning line, or 7 when there is none. An acknowledge sets that line's in-service bit and clears its request bit when the line is in edge mode.
- R7: In automatic end-of-interrupt mode, an acknowledge leaves the in-service register unchanged. If rotate-on-auto-EOI is on, the offset becomes (level + 1) mod 8.
- R8: An address-0 write with bits 4 and 3 both clear is a command taken from bits 7:5, as follows:
  - 0 and 4 clear and set rotate-on-auto-EOI.
  - 1 clears the best-ranked in-service bit.
  - 5 does the same as 1 and also sets the offset to that line + 1.
  - 3 clears the in-service bit named by bits 2:0.
  - 7 does the same as 3 and also sets the offset to that line + 1.
  - 6 sets the offset to bits 2:0 + 1.
  - 2 has no effect.
- R9: An address-0 write with bit 4 set starts initialization. It clears the mask, in-service, request, offset and all modes. Bit 0 requests a fourth word and bit 1 selects single mode. The next address-1 write stores bits 7:3 as the vector base. A third word follows only when single mode is off. The fourth word sets fully nested mode from bit 4 and automatic end-of-interrupt from bit 1.
- R10: An address-0 write with bit 3 set and bit 4 clear works as follows. Bit 2 arms poll. When bit 1 is set, bit 0 chooses whether address 0 reads in-service (1) or request (0). When bit 6 is set, bit 5 sets special mask mode.
- R11: A read while poll is armed acknowledges the winner and returns 8'h80 OR its line, or returns 0 when there is no winner. The read then disarms poll.
- R12: An address-1 write outside initialization loads the mask register. An address-1 read returns the mask.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| irq_in | input | 8 | Interrupt request lines |
| wr_en | input | 1 | Register write strobe |
| rd_en | input | 1 | Register read strobe (has side effects when poll is armed) |
| addr | input | 1 | Register address |
| wdata | input | 8 | Write data |
| rdata | output | 8 | Read data, valid while rd_en is high |
| trig_wr | input | 1 | Trigger-mode register write strobe |
| trig_data | input | 8 | Trigger-mode write data, 1 = level |
| ack | input | 1 | Interrupt acknowledge |
| ack_level | output | 3 | Current winning line, 7 when none |
| vec_base | output | 5 | Stored vector base |
| int_req | output | 1 | Registered interrupt request |

## Verification
The bench targets rank comparisons that change when the offset moves. An offset update that is missed or applied twice makes a different line win after a rotating end-of-interrupt, a specific rotate or a rotate-on-auto-EOI acknowledge. It also blocks a request that is outranked only by a masked or cascade in-service bit. A design that fails to exclude such bits in special mask or fully nested mode keeps the request low there.

A second group of checks covers the initialization sequence and the capture logic. If the sequencer does not skip the third word in single mode, it swallows the next mask write. If the capture logic treats a held line as fresh, it re-triggers after an acknowledge. If it ignores the capability mask, it lets a forced edge line follow its input. A poll that stays armed returns a poll byte where the mask should appear.

// File: rtl/rotprio_pkg.sv
package rotprio_pkg;

   typedef enum logic [1:0] {
      SEQ_IDLE  = 2'd0,
      SEQ_BASE  = 2'd1,
      SEQ_CASC  = 2'd2,
      SEQ_MODE  = 2'd3
   } seq_state_e;

   typedef enum logic [2:0] {
      OP_ROT_OFF  = 3'd0,
      OP_EOI_TOP  = 3'd1,
      OP_NONE     = 3'd2,
      OP_EOI_LINE = 3'd3,
      OP_ROT_ON   = 3'd4,
      OP_EOI_ROT  = 3'd5,
      OP_SET_PRI  = 3'd6,
      OP_LINE_ROT = 3'd7
   } op_code_e;

endpackage

// File: rtl/rotprio_scan.sv
module rotprio_scan #(
   parameter int LVL_W = 3
) (
   input  logic [(1<<LVL_W)-1:0] req,
   input  logic [LVL_W-1:0]      offs,
   output logic                  found,
   output logic [LVL_W-1:0]      level
);
   localparam int N = 1 << LVL_W;

   logic [2*N-1:0] dbl;
   logic [N-1:0]   rot;
   logic [LVL_W-1:0] rank;

   assign dbl = {req, req} >> offs;
   assign rot = dbl[N-1:0];

   always_comb begin
      rank = '0;
      for (int i = N - 1; i >= 0; i--) begin
         if (rot[i]) rank = LVL_W'(i);
      end
   end

   assign found = |rot;
   assign level = rank + offs;
endmodule

// File: rtl/rotprio_capture.sv
module rotprio_capture #(
   parameter int N = 8
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic [N-1:0] irq_in,
   input  logic [N-1:0] trig,
   input  logic         clr_all,
   input  logic [N-1:0] ack_clr,
   output logic [N-1:0] irr
);
   logic [N-1:0] prev;

   for (genvar g = 0; g < N; g++) begin : g_line
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n) begin
            irr[g]  <= 1'b0;
            prev[g] <= 1'b0;
         end else if (clr_all) begin
            irr[g]  <= 1'b0;
            prev[g] <= 1'b0;
         end else begin
            prev[g] <= irq_in[g];
            if (trig[g])
               irr[g] <= irq_in[g];
            else if (irq_in[g] && !prev[g])
               irr[g] <= 1'b1;
            else if (ack_clr[g])
               irr[g] <= 1'b0;
         end
      end
   end

   assert_level_follow_R3: assert property (@(posedge clk) disable iff (!rst_n)
      !clr_all |=> ((irr & $past(trig)) == ($past(irq_in) & $past(trig))));

   assert_edge_set_R2: assert property (@(posedge clk) disable iff (!rst_n)
      !clr_all |=> ((irr & $past(irq_in & ~prev & ~trig)) == $past(irq_in & ~prev & ~trig)));
endmodule

// File: rtl/rotprio_intc.sv
module rotprio_intc
   import rotprio_pkg::*;
#(
   parameter int           LVL_W     = 3,
   parameter bit           IS_MASTER = 1'b1,
   parameter int           CASC_LINE = 2,
   parameter logic [7:0]   TRIG_MASK = 8'hF8
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic [7:0]       irq_in,
   input  logic             wr_en,
   input  logic             rd_en,
   input  logic             addr,
   input  logic [7:0]       wdata,
   output logic [7:0]       rdata,
   input  logic             trig_wr,
   input  logic [7:0]       trig_data,
   input  logic             ack,
   output logic [2:0]       ack_level,
   output logic [4:0]       vec_base,
   output logic             int_req
);
   localparam int N      = 1 << LVL_W;
   localparam int BASE_W = 8 - LVL_W;

   if (LVL_W != 3) begin : g_bad_width
      $error("rotprio_intc: LVL_W must be 3 for a byte-wide register port");
   end
   if (CASC_LINE < 0 || CASC_LINE >= N) begin : g_bad_casc
      $error("rotprio_intc: CASC_LINE out of range");
   end

   // state
   logic [N-1:0]      imr, isr, trig;
   logic [LVL_W-1:0]  offs;
   logic              rot_aeoi, aeoi, sfnm, smm, poll, rsel, need_w4, single;
   logic [BASE_W-1:0] base;
   seq_state_e        seq;

   logic [N-1:0]      imr_n, isr_n;
   logic [LVL_W-1:0]  offs_n;
   logic              rot_aeoi_n, aeoi_n, sfnm_n, smm_n, poll_n, rsel_n, need_w4_n, single_n;
   logic [BASE_W-1:0] base_n;
   seq_state_e        seq_n;

   logic [N-1:0]      irr, ack_clr, cmp_mask, casc_keep;
   logic              init_clr;

   // trigger capture
   rotprio_capture #(.N(N)) u_capture (
      .clk     (clk),
      .rst_n   (rst_n),
      .irq_in  (irq_in),
      .trig    (trig),
      .clr_all (init_clr),
      .ack_clr (ack_clr),
      .irr     (irr)
   );

   // priority resolution
   logic             req_found, cmp_found, eoi_found;
   logic [LVL_W-1:0] req_level, cmp_level, eoi_level;
   logic [LVL_W-1:0] req_rank, cmp_rank;
   logic             win;
   logic [LVL_W-1:0] win_level;

   if (IS_MASTER) begin : g_master
      assign casc_keep = sfnm ? ~(N'(1) << CASC_LINE) : '1;
   end else begin : g_slave
      assign casc_keep = '1;
   end

   assign cmp_mask = isr & (smm ? ~imr : '1) & casc_keep;

   rotprio_scan #(.LVL_W(LVL_W)) u_scan_req (
      .req (irr & ~imr), .offs (offs), .found (req_found), .level (req_level));
   rotprio_scan #(.LVL_W(LVL_W)) u_scan_cmp (
      .req (cmp_mask),   .offs (offs), .found (cmp_found), .level (cmp_level));
   rotprio_scan #(.LVL_W(LVL_W)) u_scan_eoi (
      .req (isr),        .offs (offs), .found (eoi_found), .level (eoi_level));

   assign req_rank  = req_level - offs;
   assign cmp_rank  = cmp_level - offs;
   assign win       = req_found && (!cmp_found || (req_rank < cmp_rank));
   assign win_level = req_level;
   assign ack_level = win ? win_level : 3'd7;
   assign vec_base  = base;

   // read multiplexer
   always_comb begin
      if (poll)
         rdata = win ? {1'b1, {(N-1-LVL_W){1'b0}}, win_level} : '0;
      else if (!addr)
         rdata = rsel ? isr : irr;
      else
         rdata = imr;
   end

   // command decode and next state
   logic do_ack;
   op_code_e op;
   assign op = op_code_e'(wdata[7:5]);
   assign do_ack = (ack || (rd_en && poll)) && win;

   always_comb begin
      imr_n = imr;  isr_n = isr;  offs_n = offs;
      rot_aeoi_n = rot_aeoi;  aeoi_n = aeoi;  sfnm_n = sfnm;  smm_n = smm;
      poll_n = poll;  rsel_n = rsel;  need_w4_n = need_w4;  single_n = single;
      base_n = base;  seq_n = seq;
      ack_clr = '0;  init_clr = 1'b0;

      if (rd_en && poll) poll_n = 1'b0;

      if (do_ack) begin
         ack_clr = N'(1) << win_level;
         if (aeoi) begin
            if (rot_aeoi) offs_n = win_level + 1'b1;
         end else begin
            isr_n[win_level] = 1'b1;
         end
      end

      if (wr_en) begin
         if (!addr) begin
            if (wdata[4]) begin
               init_clr = 1'b1;
               imr_n = '0;  isr_n = '0;  offs_n = '0;
               rot_aeoi_n = 1'b0;  aeoi_n = 1'b0;  sfnm_n = 1'b0;  smm_n = 1'b0;
               poll_n = 1'b0;  rsel_n = 1'b0;  base_n = '0;
               need_w4_n = wdata[0];
               single_n  = wdata[1];
               seq_n     = SEQ_BASE;
            end else if (wdata[3]) begin
               if (wdata[2]) poll_n = 1'b1;
               if (wdata[1]) rsel_n = wdata[0];
               if (wdata[6]) smm_n  = wdata[5];
            end else begin
               case (op)
                  OP_ROT_OFF: rot_aeoi_n = 1'b0;
                  OP_ROT_ON:  rot_aeoi_n = 1'b1;
                  OP_EOI_TOP, OP_EOI_ROT: begin
                     if (eoi_found) begin
                        isr_n[eoi_level] = 1'b0;
                        if (op == OP_EOI_ROT) offs_n = eoi_level + 1'b1;
                     end
                  end
                  OP_EOI_LINE: isr_n[wdata[LVL_W-1:0]] = 1'b0;
                  OP_SET_PRI:  offs_n = wdata[LVL_W-1:0] + 1'b1;
                  OP_LINE_ROT: begin
                     isr_n[wdata[LVL_W-1:0]] = 1'b0;
                     offs_n = wdata[LVL_W-1:0] + 1'b1;
                  end
                  default: ;
               endcase
            end
         end else begin
            case (seq)
               SEQ_IDLE: imr_n = wdata;
               SEQ_BASE: begin
                  base_n = wdata[7:LVL_W];
                  seq_n  = single ? (need_w4 ? SEQ_MODE : SEQ_IDLE) : SEQ_CASC;
               end
               SEQ_CASC: seq_n = need_w4 ? SEQ_MODE : SEQ_IDLE;
               SEQ_MODE: begin
                  sfnm_n = wdata[4];
                  aeoi_n = wdata[1];
                  seq_n  = SEQ_IDLE;
               end
               default: seq_n = SEQ_IDLE;
            endcase
         end
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         imr <= '0;  isr <= '0;  trig <= '0;  offs <= '0;
         rot_aeoi <= 1'b0;  aeoi <= 1'b0;  sfnm <= 1'b0;  smm <= 1'b0;
         poll <= 1'b0;  rsel <= 1'b0;  need_w4 <= 1'b0;  single <= 1'b0;
         base <= '0;  seq <= SEQ_IDLE;  int_req <= 1'b0;
      end else begin
         imr <= imr_n;  isr <= isr_n;  offs <= offs_n;
         rot_aeoi <= rot_aeoi_n;  aeoi <= aeoi_n;  sfnm <= sfnm_n;  smm <= smm_n;
         poll <= poll_n;  rsel <= rsel_n;  need_w4 <= need_w4_n;  single <= single_n;
         base <= base_n;  seq <= seq_n;
         if (trig_wr) trig <= trig_data & TRIG_MASK;
         int_req <= win;
      end
   end

   // assertions
   assert_int_cause_R4: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(int_req) |-> $past(|(irr & ~imr)));

   assert_aeoi_isr_R7: assert property (@(posedge clk) disable iff (!rst_n)
      (ack && aeoi && !wr_en) |=> $stable(isr));

   assert_aeoi_rot_R7: assert property (@(posedge clk) disable iff (!rst_n)
      (ack && win && aeoi && rot_aeoi && !wr_en) |=> (offs == $past(win_level + 3'd1)));

   assert_poll_clear_R11: assert property (@(posedge clk) disable iff (!rst_n)
      (rd_en && poll && !wr_en) |=> !poll);

   assert_base_store_R9: assert property (@(posedge clk) disable iff (!rst_n)
      (wr_en && addr && seq == SEQ_BASE) |=> (vec_base == $past(wdata[7:3])));

   assert_mask_load_R12: assert property (@(posedge clk) disable iff (!rst_n)
      (wr_en && addr && seq == SEQ_IDLE) |=> (imr == $past(wdata)));
endmodule

// File: tb/rotprio_intc_test.sv
`timescale 1ns/1ps
module rotprio_intc_test;
   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic [7:0] irq_in = '0;
   logic       wr_en = 1'b0, rd_en = 1'b0, addr = 1'b0;
   logic [7:0] wdata = '0;
   logic [7:0] rdata;
   logic       trig_wr = 1'b0;
   logic [7:0] trig_data = '0;
   logic       ack = 1'b0;
   logic [2:0] ack_level;
   logic [4:0] vec_base;
   logic       int_req;

   int checks = 0;
   int errors = 0;

   always #4 clk = ~clk;

   rotprio_intc uut (
      .clk(clk), .rst_n(rst_n), .irq_in(irq_in), .wr_en(wr_en), .rd_en(rd_en),
      .addr(addr), .wdata(wdata), .rdata(rdata), .trig_wr(trig_wr),
      .trig_data(trig_data), .ack(ack), .ack_level(ack_level),
      .vec_base(vec_base), .int_req(int_req)
   );

   task automatic chk(input string tag, input logic [7:0] act, input logic [7:0] exp);
      checks++;
      if (act !== exp) begin
         errors++;
         $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
      end
   endtask

   task automatic wr(input logic a, input logic [7:0] d);
      @(negedge clk); addr = a; wdata = d; wr_en = 1'b1;
      @(negedge clk); wr_en = 1'b0;
   endtask

   task automatic rd(input logic a, output logic [7:0] d);
      @(negedge clk); addr = a; rd_en = 1'b1;
      #1 d = rdata;
      @(negedge clk); rd_en = 1'b0;
   endtask

   task automatic settle();
      repeat (3) @(negedge clk);
   endtask

   task automatic pulse_ack();
      @(negedge clk); ack = 1'b1;
      @(negedge clk); ack = 1'b0;
   endtask

   task automatic set_trig(input logic [7:0] t);
      @(negedge clk); trig_data = t; trig_wr = 1'b1;
      @(negedge clk); trig_wr = 1'b0;
   endtask

   task automatic set_irq(input logic [7:0] v);
      @(negedge clk); irq_in = v;
   endtask

   task automatic init_std(input logic fn, input logic ae);
      wr(1'b0, 8'h11);
      wr(1'b1, 8'h20);
      wr(1'b1, 8'h04);
      wr(1'b1, {3'b000, fn, 2'b00, ae, 1'b1});
   endtask

   task automatic t_reset();
      logic [7:0] d;
      chk("R1 int_req", {7'b0, int_req}, 8'h00);
      chk("R1 ack_level", {5'b0, ack_level}, 8'h07);
      chk("R1 vec_base", {3'b0, vec_base}, 8'h00);
      rd(1'b1, d); chk("R1 mask", d, 8'h00);
      rd(1'b0, d); chk("R1 request", d, 8'h00);
   endtask

   task automatic t_init();
      logic [7:0] d;
      wr(1'b1, 8'h5A);
      wr(1'b0, 8'h13);
      rd(1'b1, d); chk("R9 mask cleared by init", d, 8'h00);
      wr(1'b1, 8'h48);
      wr(1'b1, 8'h02);
      chk("R9 vector base single", {3'b0, vec_base}, 8'h09);
      wr(1'b1, 8'hFF);
      rd(1'b1, d); chk("R12 mask load after single init", d, 8'hFF);
      init_std(1'b0, 1'b0);
      chk("R9 vector base cascade", {3'b0, vec_base}, 8'h04);
      rd(1'b1, d); chk("R9 mask after cascade init", d, 8'h00);
   endtask

   task automatic t_edge();
      logic [7:0] d;
      init_std(1'b0, 1'b0);
      set_trig(8'h00);
      set_irq(8'h20); settle();
      chk("R4 int_req on request", {7'b0, int_req}, 8'h01);
      chk("R6 ack_level", {5'b0, ack_level}, 8'h05);
      set_irq(8'h00); settle();
      rd(1'b0, d); chk("R2 edge bit held", d, 8'h20);
      pulse_ack(); settle();
      rd(1'b0, d); chk("R6 edge request cleared", d, 8'h00);
      chk("R6 int_req dropped", {7'b0, int_req}, 8'h00);
      wr(1'b0, 8'h0B);
      rd(1'b0, d); chk("R10 read in-service", d, 8'h20);
      wr(1'b0, 8'h20);
      rd(1'b0, d); chk("R8 non-specific EOI", d, 8'h00);
      set_irq(8'h20); settle();
      pulse_ack(); settle();
      wr(1'b0, 8'h0A);
      rd(1'b0, d); chk("R2 no retrigger while held", d, 8'h00);
      wr(1'b0, 8'h20);
      set_irq(8'h00); settle();
   endtask

   task automatic t_level();
      logic [7:0] d;
      init_std(1'b0, 1'b0);
      set_trig(8'hFF);
      set_irq(8'h0A); settle();
      rd(1'b0, d); chk("R3 level and edge capture", d, 8'h0A);
      set_irq(8'h00); settle();
      rd(1'b0, d); chk("R3 level follows, masked line stays edge", d, 8'h02);
      pulse_ack();
      wr(1'b0, 8'h20);
      set_trig(8'h00);
   endtask

   task automatic t_priority();
      init_std(1'b0, 1'b0);
      set_irq(8'h54); settle();
      chk("R4 lowest rank wins", {5'b0, ack_level}, 8'h02);
      wr(1'b1, 8'h04); settle();
      chk("R4 masked line skipped", {5'b0, ack_level}, 8'h04);
      wr(1'b0, 8'hC4); settle();
      chk("R4 offset moves top rank", {5'b0, ack_level}, 8'h06);
      pulse_ack(); settle();
      chk("R5 blocked by in-service", {7'b0, int_req}, 8'h00);
      chk("R6 no winner level", {5'b0, ack_level}, 8'h07);
      wr(1'b0, 8'hC7); settle();
      chk("R5 outranks in-service", {7'b0, int_req}, 8'h01);
      chk("R5 winner level", {5'b0, ack_level}, 8'h04);
      wr(1'b0, 8'hC4); settle();
      chk("R5 blocked again", {7'b0, int_req}, 8'h00);
      wr(1'b1, 8'h44);
      wr(1'b0, 8'h68); settle();
      chk("R10 special mask unblocks", {7'b0, int_req}, 8'h01);
      wr(1'b0, 8'h48); settle();
      chk("R10 special mask off blocks", {7'b0, int_req}, 8'h00);
      set_irq(8'h00); settle();
   endtask

   task automatic t_nested();
      init_std(1'b1, 1'b0);
      set_irq(8'h04); settle(); pulse_ack(); settle();
      set_irq(8'h00); settle(); set_irq(8'h04); settle();
      chk("R5 fully nested ignores cascade in-service", {7'b0, int_req}, 8'h01);
      chk("R5 fully nested level", {5'b0, ack_level}, 8'h02);
      set_irq(8'h00);
      init_std(1'b0, 1'b0);
      set_irq(8'h04); settle(); pulse_ack(); settle();
      set_irq(8'h00); settle(); set_irq(8'h04); settle();
      chk("R5 normal nesting blocks same line", {7'b0, int_req}, 8'h00);
      set_irq(8'h00); settle();
   endtask

   task automatic t_aeoi();
      logic [7:0] d;
      init_std(1'b0, 1'b1);
      wr(1'b0, 8'h80);
      set_irq(8'h08); settle();
      chk("R7 winner before auto ack", {5'b0, ack_level}, 8'h03);
      pulse_ack(); settle();
      wr(1'b0, 8'h0B);
      rd(1'b0, d); chk("R7 auto EOI leaves in-service clear", d, 8'h00);
      set_irq(8'h00); settle();
      set_irq(8'h22); settle();
      chk("R7 rotated on auto EOI", {5'b0, ack_level}, 8'h05);
      wr(1'b0, 8'h00);
      pulse_ack(); settle();
      set_irq(8'h72); settle();
      chk("R8 rotate-on-auto-EOI cleared", {5'b0, ack_level}, 8'h04);
      set_irq(8'h00); settle();
   endtask

   task automatic t_cmds();
      logic [7:0] d;
      init_std(1'b0, 1'b0);
      set_irq(8'h20); settle(); pulse_ack(); settle();
      set_irq(8'h28); settle(); pulse_ack(); settle();
      set_irq(8'h2A); settle(); pulse_ack(); settle();
      wr(1'b0, 8'h0B);
      rd(1'b0, d); chk("R6 nested in-service", d, 8'h2A);
      wr(1'b0, 8'h63);
      rd(1'b0, d); chk("R8 specific EOI", d, 8'h22);
      wr(1'b0, 8'h40);
      rd(1'b0, d); chk("R8 no-op command", d, 8'h22);
      wr(1'b0, 8'hA0);
      rd(1'b0, d); chk("R8 rotating EOI clears top", d, 8'h20);
      set_irq(8'h00); settle();
      set_irq(8'h09); settle();
      chk("R8 rotating EOI offset", {5'b0, ack_level}, 8'h03);
      wr(1'b0, 8'hE5); settle();
      chk("R8 specific rotate", {5'b0, ack_level}, 8'h00);
      set_irq(8'h00); settle();
   endtask

   task automatic t_poll();
      logic [7:0] d;
      init_std(1'b0, 1'b0);
      wr(1'b1, 8'h80);
      wr(1'b0, 8'h0C);
      rd(1'b0, d); chk("R11 poll with no winner", d, 8'h00);
      rd(1'b1, d); chk("R11 poll disarmed", d, 8'h80);
      set_irq(8'h40); settle();
      wr(1'b0, 8'h0C);
      rd(1'b0, d); chk("R11 poll returns level", d, 8'h86);
      wr(1'b0, 8'h0B);
      rd(1'b0, d); chk("R11 poll acknowledged", d, 8'h40);
      set_irq(8'h00); settle();
   endtask

   initial begin
      repeat (4) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      t_reset();
      t_init();
      t_edge();
      t_level();
      t_priority();
      t_nested();
      t_aeoi();
      t_cmds();
      t_poll();
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
   end

   initial begin
      #(8 * 150000);
      checks++;
      errors++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
   end
endmodule